// File: doc/BRIEF.md
# Interrupt redirection controller

This block turns a set of external interrupt input lines into vectored delivery requests. Software reaches it through two locations: a select location that holds a register index, and a window location that reads or writes the register the index points at. The register space holds an identification register, a read-only version register, an arbitration register, and one 64-bit routing entry per input line. Each entry sets the vector, delivery mode, destination mode, destination, trigger mode and mask. It also reports a remote-pending status.

Edge-mode lines raise one request per rising transition. Level-mode lines raise a request while they are high and unmasked. After a delivery, a level line is blocked until an end-of-interrupt naming its vector arrives. If the line is still high at that point, it fires again. Requests leave through a valid/ready port that carries the vector, destination, destination mode and trigger mode. When several lines are ready to issue, the lowest-numbered one goes first.

Top module: `irq_route_ctrl`

## Requirements
- R1: A window write to index 0 updates only bits 27:24 of the identification register. Every other bit of that register reads 0 whatever was written.
- R2: Index 1 always reads {8'h00, NUM_LINES-1, 8'h00, VERSION} and ignores writes.
- R3: Index 2 reads the identification value in bits 27:24, copied at every write of index 0. Direct writes to index 2 change nothing.
- R4: The entry for line n is at index 0x10+2n (low word) and 0x10+2n+1 (high word). The low word holds vector[7:0], delivery mode[10:8], destination mode[11], remote-pending[14] (read-only), trigger[15] (1 = level) and mask[16]. The high word holds the destination in bits 31:24. Writing only the high word leaves the low word intact.
- R5: After reset every entry reads mask=1, trigger=edge, remote-pending=0 and all other fields 0. No request is valid.
- R6: An unmasked edge-mode line produces exactly one delivery per low-to-high transition, however long it stays high.
- R7: A delivery on a level line sets its remote-pending bit. An end-of-interrupt carrying the entry's vector clears the bit, and the line delivers again if it is still high.
- R8: Dropping and re-raising a level line while its remote-pending bit is set adds no delivery.
- R9: A masked line delivers nothing, and an edge seen while masked is lost on unmask. A level line that is high when unmasked delivers.
- R10: Each request carries the entry's vector, destination, destination mode and trigger mode unchanged. A destination mode of 1 marks the destination as a logical target mask.
- R11: A request held with ready low keeps valid and all its fields steady. Lines pending together issue in ascending line order.
- R12: An end-of-interrupt whose vector differs from the entry's vector leaves remote-pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | 0 = index location, 1 = data window |
| bus_wr | input | 1 | Write strobe for the selected location |
| bus_wdata | input | 32 | Write data (index in bits 7:0) |
| bus_rdata | output | 32 | Contents of the register named by the index |
| irq_in | input | NUM_LINES | Interrupt input lines, synchronous to clk |
| eoi_valid | input | 1 | End-of-interrupt notification strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Receiver accepts the request |
| dlv_vector | output | 8 | Vector of the request |
| dlv_dest | output | 8 | Destination ID or logical mask |
| dlv_logical | output | 1 | 1 = logical destination mode |
| dlv_level | output | 1 | 1 = level-triggered source |

## Verification
The assertions assume that the input lines and the end-of-interrupt strobe are already synchronous to clk. They also assume an end-of-interrupt is a single-cycle pulse. The bench changes every input one time unit after a rising edge and holds each end-of-interrupt for exactly one cycle. The hold assertion also assumes dlv_ready is not tied to dlv_valid. The bench drives ready on its own, including long stretches with ready low while requests queue up.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       remote;
    logic       logical;
    logic [2:0] dmode;
    logic [7:0] vector;
  } redir_t;

  localparam logic [7:0] TABLE_BASE = 8'h10;
  localparam logic [7:0] IDX_ID     = 8'h00;
  localparam logic [7:0] IDX_VER    = 8'h01;
  localparam logic [7:0] IDX_ARB    = 8'h02;

  function automatic logic [31:0] low_word(input redir_t e);
    return {15'd0, e.mask, e.level, e.remote, 2'b00, e.logical, e.dmode, e.vector};
  endfunction

  function automatic logic [31:0] high_word(input redir_t e);
    return {e.dest, 24'd0};
  endfunction

  function automatic redir_t entry_at_reset();
    redir_t e;
    e = '0;
    e.mask = 1'b1;
    return e;
  endfunction

  function automatic logic [31:0] version_word(input logic [7:0] ver, input int lines);
    return {8'h00, 8'(lines - 1), 8'h00, ver};
  endfunction

endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_route_pkg::*;
#(
  parameter int         NUM_LINES = 8,
  parameter logic [7:0] VERSION   = 8'h20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] grant,
  input  logic                 eoi_valid,
  input  logic [7:0]           eoi_vector,
  output redir_t               entries [NUM_LINES]
);

  logic [7:0] index_q;
  logic [3:0] id_q;
  logic [3:0] arb_q;
  redir_t     ent_q [NUM_LINES];

  logic       index_wr, data_wr;
  logic [7:0] rel;
  logic [NUM_LINES-1:0] hit_lo, hit_hi;
  logic       unused_wbits;

  assign index_wr     = bus_wr && !bus_sel;
  assign data_wr      = bus_wr && bus_sel;
  assign rel          = index_q - TABLE_BASE;
  assign unused_wbits = ^bus_wdata[23:17];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      id_q    <= '0;
      arb_q   <= '0;
    end else begin
      if (index_wr) index_q <= bus_wdata[7:0];
      if (data_wr && index_q == IDX_ID) begin
        id_q  <= bus_wdata[27:24];
        arb_q <= bus_wdata[27:24];
      end
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_ent
    assign hit_lo[i] = (index_q >= TABLE_BASE) && (rel == 8'(2 * i));
    assign hit_hi[i] = (index_q >= TABLE_BASE) && (rel == 8'(2 * i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[i] <= entry_at_reset();
      end else begin
        if (data_wr && hit_lo[i]) begin
          ent_q[i].vector  <= bus_wdata[7:0];
          ent_q[i].dmode   <= bus_wdata[10:8];
          ent_q[i].logical <= bus_wdata[11];
          ent_q[i].level   <= bus_wdata[15];
          ent_q[i].mask    <= bus_wdata[16];
          if (!bus_wdata[15]) ent_q[i].remote <= 1'b0;
        end
        if (data_wr && hit_hi[i]) ent_q[i].dest <= bus_wdata[31:24];
        if (grant[i] && ent_q[i].level)
          ent_q[i].remote <= 1'b1;
        else if (eoi_valid && ent_q[i].remote && eoi_vector == ent_q[i].vector)
          ent_q[i].remote <= 1'b0;
      end
    end

    assign entries[i] = ent_q[i];

    // R7: a level delivery leaves the line blocked
    a_r7_remote_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && ent_q[i].level) |=> ent_q[i].remote);
    // R12: a foreign vector does not release the line
    a_r12_foreign_eoi_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_q[i].remote && eoi_valid && eoi_vector != ent_q[i].vector && !(data_wr && hit_lo[i]))
      |=> ent_q[i].remote);
  end

  always_comb begin
    bus_rdata = '0;
    case (index_q)
      IDX_ID:  bus_rdata = {4'd0, id_q, 24'd0};
      IDX_VER: bus_rdata = version_word(VERSION, NUM_LINES);
      IDX_ARB: bus_rdata = {4'd0, arb_q, 24'd0};
      default: begin
        for (int i = 0; i < NUM_LINES; i++) begin
          if (hit_lo[i]) bus_rdata = low_word(ent_q[i]);
          if (hit_hi[i]) bus_rdata = high_word(ent_q[i]);
        end
      end
    endcase
  end

  // R3: direct writes leave the arbitration value alone
  a_r3_arb_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && index_q == IDX_ARB) |=> $stable(arb_q));

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] mask_vec,
  input  logic [NUM_LINES-1:0] level_vec,
  input  logic [NUM_LINES-1:0] remote_vec,
  input  logic [NUM_LINES-1:0] grant,
  output logic [NUM_LINES-1:0] req
);

  logic [NUM_LINES-1:0] line_q;
  logic [NUM_LINES-1:0] edge_pend;
  logic [NUM_LINES-1:0] rise;

  assign rise = irq_in & ~line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= irq_in;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        edge_pend[i] <= 1'b0;
      else if (rise[i] && !mask_vec[i] && !level_vec[i])
        edge_pend[i] <= 1'b1;
      else if (grant[i] || mask_vec[i] || level_vec[i])
        edge_pend[i] <= 1'b0;
    end

    assign req[i] = !mask_vec[i] &&
                    (level_vec[i] ? (irq_in[i] && !remote_vec[i]) : edge_pend[i]);

    // R6: an issued edge with no fresh transition is not issued twice
    a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && !level_vec[i] && !rise[i]) |=> !req[i]);
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req,
  input  redir_t               entries [NUM_LINES],
  output logic [NUM_LINES-1:0] grant,
  output logic                 dlv_valid,
  input  logic                 dlv_ready,
  output logic [7:0]           dlv_vector,
  output logic [7:0]           dlv_dest,
  output logic                 dlv_logical,
  output logic                 dlv_level
);

  function automatic logic [NUM_LINES-1:0] lowest_set(input logic [NUM_LINES-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  logic   load;
  redir_t pick;
  logic   unused_fields;

  assign load  = (|req) && (!dlv_valid || dlv_ready);
  assign grant = load ? lowest_set(req) : '0;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (grant[i]) pick = entries[i];
  end

  assign unused_fields = ^{pick.dmode, pick.mask, pick.remote};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_valid   <= 1'b0;
      dlv_vector  <= '0;
      dlv_dest    <= '0;
      dlv_logical <= 1'b0;
      dlv_level   <= 1'b0;
    end else if (load) begin
      dlv_valid   <= 1'b1;
      dlv_vector  <= pick.vector;
      dlv_dest    <= pick.dest;
      dlv_logical <= pick.logical;
      dlv_level   <= pick.level;
    end else if (dlv_ready) begin
      dlv_valid   <= 1'b0;
    end
  end

  // R11: at most one line wins a cycle
  a_r11_one_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  // R11: a stalled request holds
  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_vector) && $stable(dlv_dest)
                                   && $stable(dlv_logical) && $stable(dlv_level)));

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int         NUM_LINES = 8,
  parameter logic [7:0] VERSION   = 8'h20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 eoi_valid,
  input  logic [7:0]           eoi_vector,
  output logic                 dlv_valid,
  input  logic                 dlv_ready,
  output logic [7:0]           dlv_vector,
  output logic [7:0]           dlv_dest,
  output logic                 dlv_logical,
  output logic                 dlv_level
);

  redir_t               entries [NUM_LINES];
  logic [NUM_LINES-1:0] grant, req;
  logic [NUM_LINES-1:0] mask_vec, level_vec, remote_vec;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_vec
    assign mask_vec[i]   = entries[i].mask;
    assign level_vec[i]  = entries[i].level;
    assign remote_vec[i] = entries[i].remote;
  end

  irq_regs #(.NUM_LINES(NUM_LINES), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .grant(grant),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .entries(entries)
  );

  irq_pending #(.NUM_LINES(NUM_LINES)) u_pending (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_vec(mask_vec),
    .level_vec(level_vec), .remote_vec(remote_vec), .grant(grant), .req(req)
  );

  irq_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .entries(entries), .grant(grant),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_vector(dlv_vector),
    .dlv_dest(dlv_dest), .dlv_logical(dlv_logical), .dlv_level(dlv_level)
  );

  // R9: a masked line never wins
  a_r9_masked_never_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & mask_vec) == '0);
  // R7: a blocked level line never wins
  a_r7_no_grant_while_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & remote_vec) == '0);

endmodule

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
  localparam int         N   = 8;
  localparam logic [7:0] VER = 8'h20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        dlv_valid, dlv_ready = 1'b1, dlv_logical, dlv_level;
  logic [7:0]  dlv_vector, dlv_dest;

  irq_route_ctrl #(.NUM_LINES(N), .VERSION(VER)) u_irq_route_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
    .dlv_logical(dlv_logical), .dlv_level(dlv_level)
  );

  int compared = 0, mismatched = 0, delivered = 0;
  logic [17:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: handshake seen mid-cycle completes at the next edge
  always @(negedge clk) begin
    if (rst_n && dlv_valid && dlv_ready) begin
      delivered++;
      if (exp_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R6/R8/R9 unexpected delivery: actual %h expected none",
                 {dlv_vector, dlv_dest, dlv_logical, dlv_level});
      end else begin
        chk(tag_q.pop_front(), {14'd0, dlv_vector, dlv_dest, dlv_logical, dlv_level},
            {14'd0, exp_q.pop_front()});
      end
    end
  end

  function automatic logic [31:0] lo(logic [7:0] vec, logic logical, logic level, logic mask);
    return {15'd0, mask, level, 3'b000, logical, 3'b000, vec};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] idx, logic [31:0] d);
    tick(1); bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = {24'd0, idx};
    tick(1); bus_sel = 1'b1; bus_wdata = d;
    tick(1); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] idx, output logic [31:0] d);
    tick(1); bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = {24'd0, idx};
    tick(1); bus_wr = 1'b0; bus_sel = 1'b1;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic rd_chk(string req, logic [7:0] idx, logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    chk(req, v, exp);
  endtask

  task automatic expect_dlv(string tag, logic [7:0] vec, logic [7:0] dest, logic logical, logic level);
    exp_q.push_back({vec, dest, logical, level});
    tag_q.push_back(tag);
  endtask

  task automatic eoi(logic [7:0] vec);
    tick(1); eoi_valid = 1'b1; eoi_vector = vec;
    tick(1); eoi_valid = 1'b0;
  endtask

  task automatic drain(string tag);
    tick(10);
    chk(tag, exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int base;
    tick(3); rst_n = 1'b1; tick(1);

    // R5 reset state
    chk("R5 valid after reset", dlv_valid, 0);
    rd_chk("R5 line3 low word", 8'h16, lo(8'h00, 0, 0, 1));
    rd_chk("R5 line7 high word", 8'h1F, 32'h0);
    rd_chk("R1 id after reset", 8'h00, 32'h0);

    // R1, R2, R3 register file
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R1 id writable bits", 8'h00, 32'h0F00_0000);
    rd_chk("R3 arb mirrors id", 8'h02, 32'h0F00_0000);
    wr(8'h02, 32'h0);
    rd_chk("R3 arb ignores write", 8'h02, 32'h0F00_0000);
    rd_chk("R2 version value", 8'h01, {8'h00, 8'(N - 1), 8'h00, VER});
    wr(8'h01, ~{8'h00, 8'(N - 1), 8'h00, VER});
    rd_chk("R2 version read only", 8'h01, {8'h00, 8'(N - 1), 8'h00, VER});
    wr(8'h00, 32'h0300_0000);
    rd_chk("R3 arb follows second id write", 8'h02, 32'h0300_0000);

    // R4, R6 edge line 2
    wr(8'h15, 32'h0500_0000);
    wr(8'h14, lo(8'h76, 0, 0, 0));
    rd_chk("R4 line2 low word", 8'h14, lo(8'h76, 0, 0, 0));
    rd_chk("R4 line2 high word", 8'h15, 32'h0500_0000);
    expect_dlv("R6 edge delivery", 8'h76, 8'h05, 0, 0);
    irq_in[2] = 1'b1;
    tick(20);
    drain("R6 one delivery while held high");
    irq_in[2] = 1'b0; tick(2);
    expect_dlv("R6 second edge", 8'h76, 8'h05, 0, 0);
    irq_in[2] = 1'b1; tick(1); irq_in[2] = 1'b0;
    drain("R6 second edge delivered once");

    // R11 priority and stall
    wr(8'h12, lo(8'h40, 0, 0, 0));
    wr(8'h18, lo(8'h50, 0, 0, 0));
    expect_dlv("R11 lower line first", 8'h40, 8'h00, 0, 0);
    expect_dlv("R11 higher line second", 8'h50, 8'h00, 0, 0);
    dlv_ready = 1'b0;
    irq_in[1] = 1'b1; irq_in[4] = 1'b1;
    tick(6);
    chk("R11 valid held under stall", dlv_valid, 1);
    chk("R11 stalled vector is lowest line", dlv_vector, 8'h40);
    dlv_ready = 1'b1;
    drain("R11 both issued");
    irq_in[1] = 1'b0; irq_in[4] = 1'b0;

    // R7, R12 level line 5
    wr(8'h1B, 32'h0100_0000);
    wr(8'h1A, lo(8'h90, 0, 1, 0));
    expect_dlv("R7 level delivery", 8'h90, 8'h01, 0, 1);
    irq_in[5] = 1'b1;
    drain("R7 single delivery while pending");
    rd_chk("R7 remote set", 8'h1A, lo(8'h90, 0, 1, 0) | 32'h4000);
    eoi(8'h91);
    drain("R12 foreign eoi gives no delivery");
    rd_chk("R12 remote kept", 8'h1A, lo(8'h90, 0, 1, 0) | 32'h4000);
    expect_dlv("R7 redelivery on eoi while high", 8'h90, 8'h01, 0, 1);
    eoi(8'h90);
    drain("R7 redelivery");
    irq_in[5] = 1'b0;
    eoi(8'h90);
    tick(4);
    rd_chk("R7 remote cleared", 8'h1A, lo(8'h90, 0, 1, 0));

    // R8 coalesce
    base = delivered;
    expect_dlv("R8 first level delivery", 8'h90, 8'h01, 0, 1);
    irq_in[5] = 1'b1; tick(4);
    irq_in[5] = 1'b0; tick(2);
    irq_in[5] = 1'b1; tick(2);
    irq_in[5] = 1'b0;
    eoi(8'h90);
    drain("R8 queue empty");
    chk("R8 one delivery for two raises", delivered - base, 1);
    rd_chk("R8 remote clear", 8'h1A, lo(8'h90, 0, 1, 0));

    // R9 masking
    base = delivered;
    wr(8'h1C, lo(8'h60, 0, 0, 1));
    irq_in[6] = 1'b1; tick(1); irq_in[6] = 1'b0;
    tick(8);
    wr(8'h1C, lo(8'h60, 0, 0, 0));
    tick(8);
    chk("R9 masked edge lost", delivered - base, 0);
    wr(8'h1E, lo(8'h70, 0, 1, 1));
    irq_in[7] = 1'b1;
    tick(8);
    chk("R9 masked level silent", delivered - base, 0);
    expect_dlv("R9 level delivers on unmask", 8'h70, 8'h00, 0, 1);
    wr(8'h1E, lo(8'h70, 0, 1, 0));
    drain("R9 unmask delivery");
    irq_in[7] = 1'b0;
    eoi(8'h70);

    // R10 logical destination, R4 high-word-only write
    wr(8'h11, 32'h0D00_0000);
    wr(8'h10, lo(8'h86, 1, 1, 0));
    expect_dlv("R10 logical mask carried", 8'h86, 8'h0D, 1, 1);
    irq_in[0] = 1'b1;
    drain("R10 delivery");
    wr(8'h11, 32'h0100_0000);
    rd_chk("R4 low word kept after high write", 8'h10, lo(8'h86, 1, 1, 0) | 32'h4000);
    rd_chk("R4 high word updated", 8'h11, 32'h0100_0000);
    irq_in[0] = 1'b0;
    eoi(8'h86);
    tick(4);
    rd_chk("R7 remote cleared line0", 8'h10, lo(8'h86, 1, 1, 0));

    summary();
    $finish;
  end

endmodule